// File: doc/BRIEF.md
# Programmable Serial Output Formatter

This block turns one set of parallel result words per sample period into a bit-serial frame. It drives a primary data line, an auxiliary data line, a derived serial clock and a sync marker. Eight source words can be selected: two I/Q pairs, magnitude, phase, frequency and gain. Any selector code above those gives a zero word. A sequence table for each line lists which words go out and in what order. A frame ends at the first slot whose valid bit is clear.

A new-sample strobe takes a snapshot of the word bus. The frame starts at the next bit boundary. It opens with one lead bit period and then shifts 16-bit words back to back, MSB first. The auxiliary line works in one of two modes. In independent mode it follows its own table, so it can feed a second destination. In paired mode it sends the odd slots of the primary table while the primary line sends the even slots, which halves the frame time. The serial clock divider, the clock polarity, the sync polarity and the sync placement are all set by static configuration inputs.

Top module: `sfmt_top`

## Requirements
- R1: While reset is held, and after it until a strobe arrives, both data lines are low, `overrun_o` is low and `sync_o` sits at its inactive level.
- R2: One bit goes out per serial clock period. The period is 2^`div_sel_i` system clocks, and codes above 4 act as 4. Data changes on the falling edge of the non-inverted serial clock and is stable on its rising edge (the active edge). `sclk_inv_i`=1 inverts `sclk_o`.
- R3: Selector codes map as follows: 0 I1, 1 Q1, 2 I2, 3 Q2, 4 magnitude, 5 phase, 6 frequency, 7 gain, 8 to 15 all-zero word. Source k is `words_i[16k+15:16k]`. Words are sent MSB first.
- R4: Table slot k is bits [5k+4:5k]. Bit 4 of a slot is the valid flag and bits 3:0 are the selector. Slots are sent in ascending order, and the list ends at the first slot with its valid flag clear.
- R5: The frame begins at the first bit boundary after the strobe has been registered. It has one lead bit period with both data lines low, followed by the words with no gaps.
- R6: With `aux_pair_i`=0 the auxiliary line sends its own table. The frame lasts as long as the longer list, and a line whose list is finished stays low.
- R7: With `aux_pair_i`=1 the primary table alone is used. Even slots go on the primary line and odd slots go on the auxiliary line in the same bit periods.
- R8: With `sync_early_i`=0, sync is active during the first bit of every primary word. With `sync_frame_only_i`=1 it is active only for the first word.
- R9: With `sync_early_i`=1, sync is active during the bit period before the first bit of a primary word: the lead period, and in per-word mode also the last bit of the word before.
- R10: `sync_inv_i`=1 makes sync active low.
- R11: A strobe that arrives while a frame is pending or being shifted sets `overrun_o`, which stays set until reset. The frame in progress keeps its snapshot.
- R12: After the last bit of a frame both data lines are low and sync is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | New-sample strobe |
| words_i | input | 128 | Eight 16-bit source words |
| div_sel_i | input | 3 | Serial clock divide code |
| sclk_inv_i | input | 1 | Invert serial clock |
| sync_inv_i | input | 1 | Sync active low |
| sync_early_i | input | 1 | Sync one bit before the word |
| sync_frame_only_i | input | 1 | Sync on first word of frame only |
| aux_pair_i | input | 1 | Auxiliary line in paired mode |
| seq_pri_i | input | 40 | Primary sequence table |
| seq_aux_i | input | 40 | Auxiliary sequence table |
| sclk_o | output | 1 | Serial clock |
| sync_o | output | 1 | Sync marker |
| sd_pri_o | output | 1 | Primary serial data |
| sd_aux_o | output | 1 | Auxiliary serial data |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
Some properties are checked on every cycle: both data lines stay low when idle and during the lead period, the data lines move only at bit boundaries, and the overrun flag sets and then stays set. Word order, the selector mapping, the frame length in both auxiliary modes, sync placement and polarity, and the serial clock rate can only be shown by the bench scenarios. The bench captures each bit on the serial clock's active edge and compares whole frames against frames built from the tables.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  localparam int SLOT_W = 5;
  localparam int SEL_W  = 4;
  localparam int NSRC   = 8;

  typedef enum logic [SEL_W-1:0] {
    SEL_I1 = 4'd0, SEL_Q1 = 4'd1, SEL_I2 = 4'd2, SEL_Q2 = 4'd3,
    SEL_MAG = 4'd4, SEL_PHS = 4'd5, SEL_FRQ = 4'd6, SEL_GAIN = 4'd7,
    SEL_ZERO = 4'd8
  } sel_e;

  typedef struct packed {
    logic             valid;
    logic [SEL_W-1:0] sel;
  } slot_t;
endpackage

// File: rtl/sfmt_clkgen.sv
module sfmt_clkgen #(
  parameter int DIV_W    = 3,
  parameter int MAX_CODE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             inv_i,
  output logic             tick_o,
  output logic             sclk_o
);
  localparam int CNT_W = (MAX_CODE < 1) ? 1 : MAX_CODE;

  logic [DIV_W-1:0] code;
  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] cnt_q, last, half;
  logic             sclk_int;

  always_comb begin
    code   = (div_i > DIV_W'(MAX_CODE)) ? DIV_W'(MAX_CODE) : div_i;
    period = (CNT_W+1)'(1) << code;
    last   = CNT_W'(period - 1'b1);
    half   = CNT_W'(period >> 1);
  end

  assign tick_o = (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // full rate: rising edge falls mid-cycle, falling edge at data change
  assign sclk_int = (code == '0) ? ~clk_i : (cnt_q >= half);
  assign sclk_o   = sclk_int ^ inv_i;
endmodule

// File: rtl/sfmt_seq_len.sv
module sfmt_seq_len
  import sfmt_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int PTR_W = 4
) (
  input  logic [SLOTS*SLOT_W-1:0] tab_i,
  output logic [PTR_W-1:0]        len_o
);
  always_comb begin
    slot_t s;
    logic  found;
    len_o = PTR_W'(SLOTS);
    found = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      s = tab_i[k*SLOT_W +: SLOT_W];
      if (!found && !s.valid) begin
        len_o = PTR_W'(k);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfmt_word_sel.sv
module sfmt_word_sel
  import sfmt_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [NSRC*WORD_W-1:0] words_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic [WORD_W-1:0]      word_o
);
  always_comb begin
    if (sel_i >= SEL_ZERO) word_o = '0;
    else                   word_o = words_i[int'(sel_i[2:0])*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/sfmt_top.sv
module sfmt_top
  import sfmt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SLOTS  = 8,
  parameter int DIV_W  = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_i,
  input  logic [NSRC*WORD_W-1:0]   words_i,
  input  logic [DIV_W-1:0]         div_sel_i,
  input  logic                     sclk_inv_i,
  input  logic                     sync_inv_i,
  input  logic                     sync_early_i,
  input  logic                     sync_frame_only_i,
  input  logic                     aux_pair_i,
  input  logic [SLOTS*SLOT_W-1:0]  seq_pri_i,
  input  logic [SLOTS*SLOT_W-1:0]  seq_aux_i,
  output logic                     sclk_o,
  output logic                     sync_o,
  output logic                     sd_pri_o,
  output logic                     sd_aux_o,
  output logic                     overrun_o
);
  localparam int PTR_W = $clog2(SLOTS + 3);
  localparam int BIT_W = $clog2(WORD_W);

  logic                    tick;
  logic                    busy_q, lead_q, pend_q, ovr_q;
  logic [BIT_W-1:0]        bit_q;
  logic [NSRC*WORD_W-1:0]  snap_q;
  logic [PTR_W-1:0]        ptr_q [2];
  logic [PTR_W-1:0]        nxt   [2];
  logic [PTR_W-1:0]        len   [2];
  logic [WORD_W-1:0]       sh_q  [2];
  logic [WORD_W-1:0]       wnxt  [2];
  logic [SLOTS*SLOT_W-1:0] tab   [2];
  logic [SEL_W-1:0]        sel   [2];
  logic [1:0]              act;
  logic [PTR_W-1:0]        step;
  logic                    done_nxt, word_end, sync_raw;

  sfmt_clkgen #(.DIV_W(DIV_W), .MAX_CODE(4)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_sel_i), .inv_i(sclk_inv_i),
    .tick_o(tick), .sclk_o(sclk_o)
  );

  assign tab[0] = seq_pri_i;
  assign tab[1] = aux_pair_i ? seq_pri_i : seq_aux_i;
  assign step   = aux_pair_i ? PTR_W'(2) : PTR_W'(1);

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [PTR_W-1:0] first;
    assign first  = (g == 1 && aux_pair_i) ? PTR_W'(1) : PTR_W'(0);
    assign nxt[g] = lead_q ? first : ptr_q[g] + step;
    assign sel[g] = (nxt[g] < PTR_W'(SLOTS))
                  ? tab[g][int'(nxt[g])*SLOT_W +: SEL_W] : SEL_ZERO;
    assign act[g] = busy_q && !lead_q && (ptr_q[g] < len[g]);

    sfmt_seq_len #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_len (
      .tab_i(tab[g]), .len_o(len[g])
    );
    sfmt_word_sel #(.WORD_W(WORD_W)) u_sel (
      .words_i(snap_q), .sel_i(sel[g]), .word_o(wnxt[g])
    );
  end

  assign done_nxt = (nxt[0] >= len[0]) && (nxt[1] >= len[1]);
  assign word_end = lead_q || (bit_q == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; lead_q <= 1'b0; pend_q <= 1'b0; ovr_q <= 1'b0;
      bit_q  <= '0;   snap_q <= '0;
      for (int i = 0; i < 2; i++) begin
        ptr_q[i] <= '0;
        sh_q[i]  <= '0;
      end
    end else begin
      if (sample_i) begin
        if (busy_q || pend_q) ovr_q <= 1'b1;
        else begin
          snap_q <= words_i;
          pend_q <= 1'b1;
        end
      end
      if (tick) begin
        if (!busy_q && pend_q) begin
          busy_q <= 1'b1;
          lead_q <= 1'b1;
          pend_q <= 1'b0;
        end else if (busy_q) begin
          if (word_end) begin
            lead_q <= 1'b0;
            bit_q  <= '0;
            for (int i = 0; i < 2; i++) begin
              ptr_q[i] <= nxt[i];
              sh_q[i]  <= wnxt[i];
            end
            if (done_nxt) busy_q <= 1'b0;
          end else begin
            bit_q <= bit_q + 1'b1;
            for (int i = 0; i < 2; i++) sh_q[i] <= sh_q[i] << 1;
          end
        end
      end
    end
  end

  always_comb begin
    sync_raw = 1'b0;
    if (busy_q && lead_q)
      sync_raw = sync_early_i && (len[0] != '0);
    else if (act[0]) begin
      if (!sync_early_i)
        sync_raw = (bit_q == '0) && (!sync_frame_only_i || ptr_q[0] == '0);
      else
        sync_raw = (bit_q == BIT_W'(WORD_W - 1)) && !sync_frame_only_i &&
                   ((ptr_q[0] + step) < len[0]);
    end
  end

  assign sd_pri_o  = act[0] & sh_q[0][WORD_W-1];
  assign sd_aux_o  = act[1] & sh_q[1][WORD_W-1];
  assign sync_o    = sync_raw ^ sync_inv_i;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/sfmt_chk.sv
module sfmt_chk #(
  parameter int SLOTS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sample_i,
  input logic               tick_i,
  input logic               busy_i,
  input logic               lead_i,
  input logic               pend_i,
  input logic               aux_pair_i,
  input logic [SLOTS*5-1:0] seq_pri_i,
  input logic [SLOTS*5-1:0] seq_aux_i,
  input logic               sd_pri_i,
  input logic               sd_aux_i,
  input logic               overrun_i
);
  p_idle_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!sd_pri_i && !sd_aux_i));

  p_lead_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && lead_i) |-> (!sd_pri_i && !sd_aux_i));

  p_bit_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (!($stable(seq_pri_i) && $stable(seq_aux_i) && $stable(aux_pair_i))
                 || ($stable(sd_pri_i) && $stable(sd_aux_i))));

  p_overrun_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && (busy_i || pend_i)) |=> overrun_i);

  p_overrun_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_i |=> overrun_i);
endmodule

bind sfmt_top sfmt_chk #(.SLOTS(SLOTS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .tick_i(tick),
  .busy_i(busy_q), .lead_i(lead_q), .pend_i(pend_q), .aux_pair_i(aux_pair_i),
  .seq_pri_i(seq_pri_i), .seq_aux_i(seq_aux_i), .sd_pri_i(sd_pri_o),
  .sd_aux_i(sd_aux_o), .overrun_i(overrun_o)
);

// File: tb/tb_sfmt_top.sv
module tb_sfmt_top;
  localparam int MAXB = 160;
  localparam int LIMIT = 190000;

  logic clk_i = 1'b0, rst_ni = 1'b0, sample_i = 1'b0;
  logic [127:0] words_i = '0, wds;
  logic [2:0] div_sel_i = '0;
  logic sclk_inv_i = 0, sync_inv_i = 0, sync_early_i = 0, sync_fo_i = 0, aux_pair_i = 0;
  logic [39:0] seq_pri_i = '0, seq_aux_i = '0;
  logic sclk_o, sync_o, sd_pri_o, sd_aux_o, overrun_o;

  int checks = 0, errors = 0, cyc = 0, ecount = 0;
  int P, e1, nb, wp, wa;
  bit arm = 0, rx_prev = 0;
  logic exp_p [MAXB], exp_a [MAXB], exp_s [MAXB];
  logic cap_p [MAXB], cap_a [MAXB], cap_s [MAXB];
  int   cap_n [MAXB];
  logic [15:0] wexp_p [8], wexp_a [8];

  sfmt_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .words_i(words_i),
    .div_sel_i(div_sel_i), .sclk_inv_i(sclk_inv_i), .sync_inv_i(sync_inv_i),
    .sync_early_i(sync_early_i), .sync_frame_only_i(sync_fo_i),
    .aux_pair_i(aux_pair_i), .seq_pri_i(seq_pri_i), .seq_aux_i(seq_aux_i),
    .sclk_o(sclk_o), .sync_o(sync_o), .sd_pri_o(sd_pri_o), .sd_aux_o(sd_aux_o),
    .overrun_o(overrun_o)
  );

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (!rst_ni) ecount <= 0; else ecount <= ecount + 1;
    if (cyc > LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // receiver: capture on the active serial clock edge
  always @(negedge clk_i) begin
    logic rx, rise;
    int idx;
    rx = sclk_o ^ sclk_inv_i;
    rise = (P == 1) || (rx && !rx_prev);
    rx_prev = rx;
    if (rst_ni && arm && rise && ecount >= e1) begin
      idx = (ecount - e1) / P;
      if (idx < MAXB) begin
        cap_p[idx] = sd_pri_o;
        cap_a[idx] = sd_aux_o;
        cap_s[idx] = sync_o ^ sync_inv_i;
        cap_n[idx] = cap_n[idx] + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int first_inv(input logic [39:0] t);
    for (int k = 0; k < 8; k++) if (!t[k*5+4]) return k;
    return 8;
  endfunction

  function automatic logic [15:0] pick(input logic [127:0] w, input logic [3:0] s);
    return s[3] ? 16'h0 : w[int'(s[2:0])*16 +: 16];
  endfunction

  task automatic build_exp();
    int np, na, nw;
    np = first_inv(seq_pri_i);
    if (aux_pair_i) begin
      wp = (np + 1) / 2; wa = np / 2;
      for (int w = 0; w < wp; w++) wexp_p[w] = pick(wds, seq_pri_i[(2*w)*5 +: 4]);
      for (int w = 0; w < wa; w++) wexp_a[w] = pick(wds, seq_pri_i[(2*w+1)*5 +: 4]);
    end else begin
      na = first_inv(seq_aux_i);
      wp = np; wa = na;
      for (int w = 0; w < wp; w++) wexp_p[w] = pick(wds, seq_pri_i[w*5 +: 4]);
      for (int w = 0; w < wa; w++) wexp_a[w] = pick(wds, seq_aux_i[w*5 +: 4]);
    end
    nw = (wp > wa) ? wp : wa;
    nb = 1 + 16 * nw;
    for (int i = 0; i < MAXB; i++) begin
      exp_p[i] = 0; exp_a[i] = 0; exp_s[i] = 0;
    end
    for (int w = 0; w < wp; w++)
      for (int b = 0; b < 16; b++) exp_p[1 + 16*w + b] = wexp_p[w][15-b];
    for (int w = 0; w < wa; w++)
      for (int b = 0; b < 16; b++) exp_a[1 + 16*w + b] = wexp_a[w][15-b];
    if (!sync_early_i) begin
      for (int w = 0; w < wp; w++) if (w == 0 || !sync_fo_i) exp_s[1 + 16*w] = 1;
    end else begin
      if (wp > 0) exp_s[0] = 1;
      if (!sync_fo_i) for (int w = 0; w < wp - 1; w++) exp_s[16*w + 16] = 1;
    end
  endtask

  task automatic gen_tab(output logic [39:0] t);
    int n;
    n = $urandom_range(0, 8);
    for (int k = 0; k < 8; k++) begin
      t[k*5+4] = (k < n) ? 1'b1 : ((k == n) ? 1'b0 : 1'($urandom % 2));
      t[k*5 +: 4] = 4'($urandom % 16);
    end
  endtask

  task automatic run_frame(input bit inject);
    int e0, target, bad_s, nw;
    logic [15:0] got;
    rst_ni = 0; sample_i = 0; arm = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!sd_pri_o && !sd_aux_o && !overrun_o, "R1 idle after reset",
        {sd_pri_o, sd_aux_o, overrun_o}, 0);
    chk(sync_o == sync_inv_i, "R1 R10 sync inactive level", sync_o, sync_inv_i);
    P = 1 << ((div_sel_i > 4) ? 4 : div_sel_i);
    build_exp();
    nw = (nb - 1) / 16;
    for (int i = 0; i < MAXB; i++) cap_n[i] = 0;
    repeat ($urandom_range(0, 5)) @(negedge clk_i);
    words_i = wds; sample_i = 1;
    e0 = ecount + 1;
    e1 = (e0 / P + 1) * P;
    arm = 1;
    @(negedge clk_i);
    sample_i = 0;
    if (inject && nw > 0) begin
      while (ecount < e1) @(negedge clk_i);
      words_i = ~wds; sample_i = 1;
      @(negedge clk_i);
      sample_i = 0;
    end
    target = e1 + (nb + 2) * P;
    while (ecount < target) @(negedge clk_i);
    arm = 0;
    // lead bit
    chk(cap_p[0] === 1'b0 && cap_a[0] === 1'b0, "R5 lead bit low", {cap_p[0], cap_a[0]}, 0);
    for (int w = 0; w < wp; w++) begin
      for (int b = 0; b < 16; b++) got[15-b] = cap_p[1 + 16*w + b];
      chk(got === wexp_p[w], aux_pair_i ? "R3 R4 R7 primary word" : "R3 R4 primary word",
          got, wexp_p[w]);
    end
    for (int w = 0; w < wa; w++) begin
      for (int b = 0; b < 16; b++) got[15-b] = cap_a[1 + 16*w + b];
      chk(got === wexp_a[w], aux_pair_i ? "R7 aux paired word" : "R6 aux own word",
          got, wexp_a[w]);
    end
    // finished line stays low inside the frame
    bad_s = 0;
    for (int i = 1; i < nb; i++)
      if (cap_p[i] !== exp_p[i] || cap_a[i] !== exp_a[i]) bad_s++;
    chk(bad_s == 0, "R6 whole frame bits", bad_s, 0);
    bad_s = 0;
    for (int i = 0; i <= nb; i++) if (cap_s[i] !== exp_s[i]) bad_s++;
    chk(bad_s == 0, sync_early_i ? "R9 R10 sync placement" : "R8 R10 sync placement",
        bad_s, 0);
    chk(cap_p[nb] === 1'b0 && cap_a[nb] === 1'b0 && cap_s[nb] === 1'b0,
        "R12 after frame", {cap_p[nb], cap_a[nb], cap_s[nb]}, 0);
    bad_s = 0;
    for (int i = 0; i <= nb; i++) if (cap_n[i] != 1) bad_s++;
    chk(bad_s == 0, "R2 one active edge per bit period", bad_s, 0);
    chk(overrun_o == (inject && nw > 0), "R11 overrun flag", overrun_o, inject && nw > 0);
  endtask

  initial begin
    void'($urandom(32'h5f0d1));
    wds = {16'h8001, 16'h7E5A, 16'hC3C3, 16'h1234, 16'hFFFF, 16'h0F0F, 16'hA55A, 16'h0001};
    // own lists, full rate
    div_sel_i = 0; aux_pair_i = 0; sync_early_i = 0; sync_fo_i = 0;
    seq_pri_i = '0; seq_aux_i = '0;
    for (int k = 0; k < 4; k++) seq_pri_i[k*5 +: 5] = {1'b1, 4'(k)};
    seq_aux_i[4:0] = {1'b1, 4'd7};
    run_frame(0);
    // paired, early per-word sync, inverted clock
    div_sel_i = 1; aux_pair_i = 1; sync_early_i = 1; sclk_inv_i = 1;
    seq_pri_i = '0;
    for (int k = 0; k < 5; k++) seq_pri_i[k*5 +: 5] = {1'b1, 4'(7 - k)};
    run_frame(0);
    // full table with zero code, divide 16, inverted early frame-only sync
    div_sel_i = 4; aux_pair_i = 0; sync_inv_i = 1; sync_fo_i = 1; sclk_inv_i = 0;
    for (int k = 0; k < 8; k++) seq_pri_i[k*5 +: 5] = {1'b1, (k == 3) ? 4'd12 : 4'(k)};
    seq_aux_i = '0;
    run_frame(0);
    // empty primary list, aux only; codes above 4 clamp
    div_sel_i = 7; sync_inv_i = 0; sync_early_i = 0; sync_fo_i = 0;
    seq_pri_i = '0; seq_pri_i[9:5] = {1'b1, 4'd2};
    seq_aux_i = '0; seq_aux_i[4:0] = {1'b1, 4'd5}; seq_aux_i[9:5] = {1'b1, 4'd9};
    run_frame(0);
    // overrun during a frame
    div_sel_i = 2; seq_pri_i[4:0] = {1'b1, 4'd1};
    run_frame(1);
    for (int i = 0; i < 20; i++) begin
      div_sel_i = 3'($urandom_range(0, 4));
      sclk_inv_i = 1'($urandom % 2); sync_inv_i = 1'($urandom % 2);
      sync_early_i = 1'($urandom % 2); sync_fo_i = 1'($urandom % 2);
      aux_pair_i = 1'($urandom % 2);
      gen_tab(seq_pri_i); gen_tab(seq_aux_i);
      for (int k = 0; k < 8; k++) wds[k*16 +: 16] = 16'($urandom);
      run_frame(i % 3 == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule